// File: doc/BRIEF.md
# Per-Line VBI Slicing Configuration Select

This block decides, at the start of every video line, how the vertical-interval data slicer should treat that line. It holds a small table of nine programmable entries. Each entry pairs a line number with a mode byte, and the mode byte carries the target field, the data service and four handling flags. A separate full-field mode byte, gated by its own enable, can act as a fallback for every line that no entry claims. When a line-start strobe arrives, the block compares the current line number and field with the table and registers the chosen configuration. The configuration then stays on the outputs until the next line start.

Software or a sequencer loads the table through a simple byte-wide write port. The slicer downstream reads the registered outputs. Those outputs are a valid flag, the 3-bit service code and four flags: filtering, FIFO routing, rejection of errored data, and error correction. The waveform slicing itself is done elsewhere.

Top module: `vbi_slice_select`

## Requirements
- R1: After reset, `cfgValid` is 0, `svcCode` is 3'b111 and all four flags are 0. All entry line registers reset to 00h and all entry mode bytes to FFh, so a line-start on line 0 gives an invalid result. The full-field enable resets to 0 and the full-field mode to FFh.
- R2: Write address map. Address 2k writes the line number of entry k and address 2k+1 writes its mode byte, for k = 0..8. Address 18 writes the full-field enable, and only data bit 0 counts. Address 19 writes the full-field mode byte.
- R3: An entry matches only when its line number equals `lineNum` and its mode bit 3 equals `fieldSel`. `fieldSel` is 0 for the first field and 1 for the second. An entry whose mode byte is FFh never matches.
- R4: When more than one entry matches, the entry with the lowest index supplies the configuration.
- R5: A matching entry always takes priority over the full-field mode. This holds even when the entry's service code is 3'b111; the line then comes out invalid.
- R6: When the full-field enable is 1 and no entry matches, the full-field mode byte is used for either field, and its bit 3 is ignored. When the enable is 0 and no entry matches, the result is invalid.
- R7: Decoding of a valid mode byte: `filtEn` = bit 7, `fifoRoute` = bit 6, `dropErr` = bit 5, `eccEn` = bit 4 and `svcCode` = bits 2:0. The service codes are 000 teletext, 001 closed caption, 010 WSS, 011 VITC, 100 VPS/EPG, 101 user 1, 110 user 2 and 111 none.
- R8: When the selected service is teletext (000), `fifoRoute` is 1 whatever bit 6 holds.
- R9: `cfgValid` is 0 when the selected mode byte is FFh or its service code is 111. While `cfgValid` is 0, `svcCode` reads 3'b111 and all four flags read 0.
- R10: The outputs change only on the clock edge at which `lineStart` is sampled high. They show the selection for the `lineNum`, `fieldSel` and table contents present at that edge, and they hold unchanged on every other edge.
- R11: Writes to addresses 20 to 31 change no stored configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 5 | Configuration register address |
| cfgWdata | input | 8 | Configuration write data |
| lineStart | input | 1 | One-cycle strobe at the start of each video line |
| lineNum | input | 8 | Current video line number |
| fieldSel | input | 1 | Current field: 0 first, 1 second |
| cfgValid | output | 1 | Selected configuration calls for slicing |
| svcCode | output | 3 | Selected data service |
| filtEn | output | 1 | Filtering enable |
| fifoRoute | output | 1 | Route sliced data to the FIFO |
| dropErr | output | 1 | Keep errored data out of the FIFO |
| eccEn | output | 1 | Error detection and correction enable |

## Verification
The assertions watch the output contract on every cycle. They check that the outputs hold between line starts, that an invalid result always shows service 111 with all flags clear, that a valid result never shows service 111, and that teletext always routes to the FIFO. The bench scenarios cover the behaviour that depends on table contents and the write history. These are the address map, line and field matching, lowest-index priority, entries overriding the full-field fallback (including an entry coded "none"), the enable gating of the fallback, and writes outside the map leaving the table untouched.

// File: rtl/vbi_slice_pkg.sv
package vbi_slice_pkg;

  localparam int VBI_ENTRIES = 9;
  localparam int IDX_W       = 4;
  localparam logic [7:0] MODE_UNUSED = 8'hFF;
  localparam logic [2:0] SVC_TTX     = 3'b000;
  localparam logic [2:0] SVC_NONE    = 3'b111;

  // strobes from control to datapath
  typedef struct packed {
    logic             lineWe;
    logic             modeWe;
    logic [IDX_W-1:0] idx;
    logic             ffEnWe;
    logic             ffModeWe;
    logic             capture;
  } strobe_t;

  typedef struct packed {
    logic       valid;
    logic [2:0] svc;
    logic       filt;
    logic       fifo;
    logic       dropErr;
    logic       ecc;
  } slice_cfg_t;

  localparam slice_cfg_t CFG_IDLE = '{valid: 1'b0, svc: SVC_NONE,
                                      filt: 1'b0, fifo: 1'b0,
                                      dropErr: 1'b0, ecc: 1'b0};

  function automatic slice_cfg_t decodeMode(input logic [7:0] m);
    slice_cfg_t r;
    if (m == MODE_UNUSED || m[2:0] == SVC_NONE) begin
      r = CFG_IDLE;
    end else begin
      r.valid   = 1'b1;
      r.svc     = m[2:0];
      r.filt    = m[7];
      r.fifo    = m[6] | (m[2:0] == SVC_TTX);
      r.dropErr = m[5];
      r.ecc     = m[4];
    end
    return r;
  endfunction

endpackage

// File: rtl/vbi_slice_ctrl.sv
module vbi_slice_ctrl
  import vbi_slice_pkg::*;
#(
  parameter int NUM_ENTRIES = VBI_ENTRIES,
  parameter int ADDR_W      = 5
) (
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              lineStart,
  output strobe_t           strb
);

  localparam logic [ADDR_W-1:0] ENTRY_REGS = ADDR_W'(2 * NUM_ENTRIES);
  localparam logic [ADDR_W-1:0] FF_EN_ADDR = ADDR_W'(2 * NUM_ENTRIES);
  localparam logic [ADDR_W-1:0] FF_MD_ADDR = ADDR_W'(2 * NUM_ENTRIES + 1);

  always_comb begin
    strb         = '0;
    strb.capture = lineStart;
    if (cfgWe) begin
      if (cfgAddr < ENTRY_REGS) begin
        strb.idx    = IDX_W'(cfgAddr >> 1);
        strb.lineWe = ~cfgAddr[0];
        strb.modeWe = cfgAddr[0];
      end else if (cfgAddr == FF_EN_ADDR) begin
        strb.ffEnWe = 1'b1;
      end else if (cfgAddr == FF_MD_ADDR) begin
        strb.ffModeWe = 1'b1;
      end
    end
  end

endmodule

// File: rtl/vbi_slice_dp.sv
module vbi_slice_dp
  import vbi_slice_pkg::*;
#(
  parameter int NUM_ENTRIES = VBI_ENTRIES,
  parameter int LINE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [7:0]        wdata,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              fieldSel,
  output slice_cfg_t        cfgOut
);

  logic [LINE_W-1:0] lineReg [NUM_ENTRIES];
  logic [7:0]        modeReg [NUM_ENTRIES];
  logic              ffEn;
  logic [7:0]        ffMode;
  logic [NUM_ENTRIES-1:0] hit;
  logic [7:0]        selMode;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lineReg[i] <= '0;
        modeReg[i] <= MODE_UNUSED;
      end else begin
        if (strb.lineWe && strb.idx == IDX_W'(i)) lineReg[i] <= LINE_W'(wdata);
        if (strb.modeWe && strb.idx == IDX_W'(i)) modeReg[i] <= wdata;
      end
    end
    assign hit[i] = (modeReg[i] != MODE_UNUSED) && (lineReg[i] == lineNum)
                    && (modeReg[i][3] == fieldSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ffEn   <= 1'b0;
      ffMode <= MODE_UNUSED;
    end else begin
      if (strb.ffEnWe)   ffEn   <= wdata[0];
      if (strb.ffModeWe) ffMode <= wdata;
    end
  end

  // lowest index wins; full-field only when no entry claims the line
  always_comb begin
    logic found;
    found   = 1'b0;
    selMode = ffEn ? ffMode : MODE_UNUSED;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!found && hit[i]) begin
        selMode = modeReg[i];
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfgOut <= CFG_IDLE;
    else if (strb.capture) cfgOut <= decodeMode(selMode);
  end

endmodule

// File: rtl/vbi_slice_select.sv
module vbi_slice_select
  import vbi_slice_pkg::*;
#(
  parameter int NUM_ENTRIES = VBI_ENTRIES,
  parameter int LINE_W      = 8,
  localparam int ADDR_W     = $clog2(2 * NUM_ENTRIES + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [7:0]        cfgWdata,
  input  logic              lineStart,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              fieldSel,
  output logic              cfgValid,
  output logic [2:0]        svcCode,
  output logic              filtEn,
  output logic              fifoRoute,
  output logic              dropErr,
  output logic              eccEn
);

  strobe_t    strb;
  slice_cfg_t cfgOut;

  vbi_slice_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) i_ctrl (
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .lineStart(lineStart), .strb(strb)
  );

  vbi_slice_dp #(.NUM_ENTRIES(NUM_ENTRIES), .LINE_W(LINE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(cfgWdata),
    .lineNum(lineNum), .fieldSel(fieldSel), .cfgOut(cfgOut)
  );

  assign cfgValid  = cfgOut.valid;
  assign svcCode   = cfgOut.svc;
  assign filtEn    = cfgOut.filt;
  assign fifoRoute = cfgOut.fifo;
  assign dropErr   = cfgOut.dropErr;
  assign eccEn     = cfgOut.ecc;

endmodule

// File: rtl/vbi_slice_checker.sv
module vbi_slice_checker (
  input logic       clk,
  input logic       rstN,
  input logic       lineStart,
  input logic       cfgValid,
  input logic [2:0] svcCode,
  input logic       filtEn,
  input logic       fifoRoute,
  input logic       dropErr,
  input logic       eccEn
);

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !lineStart |=> $stable({cfgValid, svcCode, filtEn, fifoRoute, dropErr, eccEn})); // R10

  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    !cfgValid |-> (svcCode == 3'b111 && !filtEn && !fifoRoute && !dropErr && !eccEn)); // R9

  AST_VALID_SVC: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> svcCode != 3'b111); // R9

  AST_TTX_FIFO: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && svcCode == 3'b000) |-> fifoRoute); // R8

endmodule

bind vbi_slice_select vbi_slice_checker i_chk (
  .clk(clk), .rstN(rstN), .lineStart(lineStart), .cfgValid(cfgValid),
  .svcCode(svcCode), .filtEn(filtEn), .fifoRoute(fifoRoute),
  .dropErr(dropErr), .eccEn(eccEn)
);

// File: tb/test_vbi_slice_select.sv
module test_vbi_slice_select;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [4:0] cfgAddr = '0;
  logic [7:0] cfgWdata = '0;
  logic       lineStart = 1'b0;
  logic [7:0] lineNum = '0;
  logic       fieldSel = 1'b0;
  logic       cfgValid, filtEn, fifoRoute, dropErr, eccEn;
  logic [2:0] svcCode;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vbi_slice_select i_vbi_slice_select (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .lineStart(lineStart), .lineNum(lineNum),
    .fieldSel(fieldSel), .cfgValid(cfgValid), .svcCode(svcCode),
    .filtEn(filtEn), .fifoRoute(fifoRoute), .dropErr(dropErr), .eccEn(eccEn)
  );

  // expected {valid, svc[2:0], filt, fifo, dropErr, ecc} from a mode byte (R7, R8, R9)
  function automatic logic [7:0] expect_of(input logic [7:0] m);
    if (m == 8'hFF || m[2:0] == 3'b111) return {1'b0, 3'b111, 4'b0000};
    return {1'b1, m[2:0], m[7], (m[6] || m[2:0] == 3'b000), m[5], m[4]};
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    logic [7:0] act;
    act = {cfgValid, svcCode, filtEn, fifoRoute, dropErr, eccEn};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic probe(input logic [7:0] ln, input logic fld);
    @(negedge clk);
    lineNum = ln; fieldSel = fld; lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset outputs", {1'b0, 3'b111, 4'b0});
    probe(8'd0, 1'b0);
    check("R1 line 0 after reset", {1'b0, 3'b111, 4'b0});
    probe(8'd0, 1'b1);
    check("R1 line 0 field 2 after reset", {1'b0, 3'b111, 4'b0});
  endtask

  task automatic t_match();
    writeReg(5'd0, 8'd21); writeReg(5'd1, 8'h01);
    writeReg(5'd2, 8'd21); writeReg(5'd3, 8'h09);
    probe(8'd21, 1'b0);
    check("R2 R3 entry0 field 1", expect_of(8'h01));
    probe(8'd21, 1'b1);
    check("R3 entry1 field 2", expect_of(8'h09));
    probe(8'd22, 1'b0);
    check("R3 no line match", expect_of(8'hFF));
  endtask

  task automatic t_decode();
    writeReg(5'd4, 8'd20); writeReg(5'd5, 8'hB2);
    probe(8'd20, 1'b0);
    check("R7 decode B2h", {1'b1, 3'b010, 1'b1, 1'b0, 1'b1, 1'b1});
    probe(8'd20, 1'b1);
    check("R3 field mismatch", expect_of(8'hFF));
    writeReg(5'd5, 8'h7C);
    probe(8'd20, 1'b1);
    check("R7 decode 7Ch", {1'b1, 3'b100, 1'b0, 1'b1, 1'b1, 1'b1});
  endtask

  task automatic t_teletext();
    writeReg(5'd6, 8'd10); writeReg(5'd7, 8'h00);
    probe(8'd10, 1'b0);
    check("R8 teletext forced to FIFO", {1'b1, 3'b000, 4'b0100});
    writeReg(5'd7, 8'h98);
    probe(8'd10, 1'b1);
    check("R8 teletext field 2", {1'b1, 3'b000, 1'b1, 1'b1, 1'b0, 1'b1});
  endtask

  task automatic t_priority();
    writeReg(5'd10, 8'd30); writeReg(5'd11, 8'h03);
    writeReg(5'd8, 8'd30);  writeReg(5'd9, 8'h04);
    probe(8'd30, 1'b0);
    check("R4 lowest index wins", expect_of(8'h04));
    writeReg(5'd9, 8'hFF);
    probe(8'd30, 1'b0);
    check("R3 R4 unused entry skipped", expect_of(8'h03));
  endtask

  task automatic t_fullfield();
    writeReg(5'd19, 8'h86);
    probe(8'd50, 1'b1);
    check("R6 full-field disabled", expect_of(8'hFF));
    writeReg(5'd18, 8'h01);
    probe(8'd50, 1'b1);
    check("R6 full-field field 2", {1'b1, 3'b110, 1'b1, 3'b000});
    probe(8'd50, 1'b0);
    check("R6 full-field field 1", {1'b1, 3'b110, 1'b1, 3'b000});
    probe(8'd30, 1'b0);
    check("R5 entry over full-field", expect_of(8'h03));
    writeReg(5'd12, 8'd40); writeReg(5'd13, 8'h07);
    probe(8'd40, 1'b0);
    check("R5 R9 none entry claims line", expect_of(8'hFF));
    writeReg(5'd18, 8'hFE);
    probe(8'd50, 1'b0);
    check("R2 R6 enable uses bit 0 only", expect_of(8'hFF));
  endtask

  task automatic t_hold();
    probe(8'd21, 1'b0);
    @(negedge clk);
    lineNum = 8'd50; fieldSel = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 hold without line start", expect_of(8'h01));
    probe(8'd50, 1'b1);
    check("R10 update on line start", expect_of(8'hFF));
  endtask

  task automatic t_ignore();
    for (int a = 20; a < 32; a++) writeReg(5'(a), 8'h01);
    probe(8'd50, 1'b0);
    check("R11 high writes leave full-field off", expect_of(8'hFF));
    probe(8'd30, 1'b0);
    check("R11 high writes leave entries", expect_of(8'h03));
    probe(8'd21, 1'b1);
    check("R11 entry1 intact", expect_of(8'h09));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_match();
    t_decode();
    t_teletext();
    t_priority();
    t_fullfield();
    t_hold();
    t_ignore();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule